// File: doc/BRIEF.md
# Dual-Clock Cascadable Up/Down Counter

This block is a small binary counter with two separate count inputs. A rising transition on one input adds one to the count, and a rising transition on the other subtracts one. One system clock samples both inputs, and the count changes on the system clock edge that follows a detected rising transition. An active-high clear and an active-low preset load both take priority over counting. The clear also wins over the load.

Two active-low outputs flag when the count is at its top or bottom value while the matching count input is low. The counter wraps in both directions. When the count input rises again, the flag returns high, and that edge advances the next stage in the same system cycle in which this stage wraps. Because of this, stages chain into wider counters with no extra logic: the carry output drives the next stage's increment input, and the borrow output drives its decrement input.

Top module: `updn_cascade_counter`

## Requirements
- R1: While `mr` is high at a system clock edge, `count` becomes 0 after that edge, whatever the count inputs do.
- R2: While `load_n` is low and `mr` is low at a clock edge, `count` takes the value of `preset` after that edge, and count-input transitions in that cycle have no effect on the count.
- R3: When `mr` is high and `load_n` is low at the same edge, `count` becomes 0.
- R4: A rising transition on `up_pulse` is a sample of 1 following a sample of 0 on consecutive clock edges. It adds one to `count` at the edge where the 1 is sampled, and 2^WIDTH-1 wraps to 0.
- R5: A rising transition on `dn_pulse`, detected the same way, subtracts one from `count` at that edge, and 0 wraps to 2^WIDTH-1.
- R6: If both count inputs show a rising transition at the same edge, `count` is unchanged.
- R7: With no rising transition, `count` holds. Steady high or low levels and falling transitions on the count inputs are ignored.
- R8: `carry_n` is low exactly when `count` equals 2^WIDTH-1 and `up_pulse` is low. It follows `up_pulse` within the same cycle, with no register.
- R9: `borrow_n` is low exactly when `count` equals 0 and `dn_pulse` is low. It follows `dn_pulse` within the same cycle.
- R10: Two stages chained `carry_n`→`up_pulse` and `borrow_n`→`dn_pulse` count as one counter of 2·WIDTH bits. The upper stage steps at the same clock edge at which the lower stage wraps.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock that samples every input |
| mr | input | 1 | Clear, active high, highest priority |
| load_n | input | 1 | Preset load, active low |
| preset | input | WIDTH | Value copied into the count on load |
| up_pulse | input | 1 | Increment input, acts on its rising transitions |
| dn_pulse | input | 1 | Decrement input, acts on its rising transitions |
| count | output | WIDTH | Current count |
| carry_n | output | 1 | Active-low carry, usable as the next stage's increment input |
| borrow_n | output | 1 | Active-low borrow, usable as the next stage's decrement input |

## Verification
The hardest situations to reach are the cascade corner cases, where the upper stage's step depends on a flag that falls and rises within a few system cycles. One case is simultaneous rises on both inputs while the lower stage sits at a terminal value. The other is a load that leaves a flag low and is then followed by a pulse. The bench uses loads to place the chained pair at 0xFE, 0x00 and similar boundaries. It then drives short pulse trains, pulses held across a load, and long runs of weighted random levels on both inputs. A per-stage reference model reproduces each flag, and each edge is predicted from the modelled flag.

// File: rtl/updn_pkg.sv
package updn_pkg;
   typedef enum logic [1:0] {
      STEP_HOLD = 2'b00,
      STEP_INC  = 2'b01,
      STEP_DEC  = 2'b10
   } step_t;

   localparam int unsigned LANE_UP = 0;
   localparam int unsigned LANE_DN = 1;
   localparam int unsigned LANES   = 2;

   function automatic step_t pick_step(input logic inc, input logic dec);
      if (inc && !dec)      return STEP_INC;
      else if (dec && !inc) return STEP_DEC;
      else                  return STEP_HOLD;
   endfunction
endpackage

// File: rtl/updn_rise_detect.sv
module updn_rise_detect #(
   parameter int unsigned LANES = 2
) (
   input  logic             clk,
   input  logic [LANES-1:0] lvl,
   output logic [LANES-1:0] rise
);
   if (LANES < 1) begin : g_bad_lanes
      $error("updn_rise_detect: LANES must be at least 1");
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      logic hist;
      always_ff @(posedge clk) begin
         hist <= lvl[i];
      end
      assign rise[i] = lvl[i] & ~hist;
   end
endmodule

// File: rtl/updn_step_core.sv
module updn_step_core
   import updn_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             clear,
   input  logic             load,
   input  logic [WIDTH-1:0] preset,
   input  step_t            step,
   output logic [WIDTH-1:0] count
);
   localparam logic [WIDTH-1:0] ONE = WIDTH'(1);

   logic [WIDTH-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (clear)
         cnt_q <= '0;
      else if (load)
         cnt_q <= preset;
      else begin
         unique case (step)
            STEP_INC: cnt_q <= cnt_q + ONE;
            STEP_DEC: cnt_q <= cnt_q - ONE;
            default:  cnt_q <= cnt_q;
         endcase
      end
   end

   assign count = cnt_q;
endmodule

// File: rtl/updn_terminal.sv
module updn_terminal #(
   parameter int unsigned WIDTH = 4
) (
   input  logic [WIDTH-1:0] count,
   input  logic             up_lvl,
   input  logic             dn_lvl,
   output logic             carry_n,
   output logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP_VAL = '1;
   localparam logic [WIDTH-1:0] BOT_VAL = '0;

   logic at_top, at_bot;

   assign at_top   = (count == TOP_VAL);
   assign at_bot   = (count == BOT_VAL);
   assign carry_n  = ~(at_top & ~up_lvl);
   assign borrow_n = ~(at_bot & ~dn_lvl);
endmodule

// File: rtl/updn_cascade_counter.sv
module updn_cascade_counter
   import updn_pkg::*;
#(
   parameter int unsigned WIDTH = 4
) (
   input  logic             clk,
   input  logic             mr,
   input  logic             load_n,
   input  logic [WIDTH-1:0] preset,
   input  logic             up_pulse,
   input  logic             dn_pulse,
   output logic [WIDTH-1:0] count,
   output logic             carry_n,
   output logic             borrow_n
);
   if (WIDTH < 1 || WIDTH > 32) begin : g_bad_width
      $error("updn_cascade_counter: WIDTH must lie in 1..32");
   end

   logic [LANES-1:0] lvl, rise;
   step_t            step;

   assign lvl[LANE_UP] = up_pulse;
   assign lvl[LANE_DN] = dn_pulse;

   updn_rise_detect #(.LANES(LANES)) u_rise (
      .clk  (clk),
      .lvl  (lvl),
      .rise (rise)
   );

   always_comb begin
      step = pick_step(rise[LANE_UP], rise[LANE_DN]);
   end

   updn_step_core #(.WIDTH(WIDTH)) u_core (
      .clk    (clk),
      .clear  (mr),
      .load   (~load_n),
      .preset (preset),
      .step   (step),
      .count  (count)
   );

   updn_terminal #(.WIDTH(WIDTH)) u_term (
      .count    (count),
      .up_lvl   (up_pulse),
      .dn_lvl   (dn_pulse),
      .carry_n  (carry_n),
      .borrow_n (borrow_n)
   );
endmodule

// File: rtl/updn_cascade_counter_chk.sv
module updn_cascade_counter_chk #(
   parameter int unsigned WIDTH = 4
) (
   input logic             clk,
   input logic             mr,
   input logic             load_n,
   input logic [WIDTH-1:0] preset,
   input logic             up_pulse,
   input logic             dn_pulse,
   input logic [WIDTH-1:0] count,
   input logic             carry_n,
   input logic             borrow_n
);
   localparam logic [WIDTH-1:0] TOP_VAL = '1;
   localparam logic [WIDTH-1:0] ONE     = WIDTH'(1);

   // R1, R3: clear wins over everything
   a_r1_clear_zero: assert property (@(posedge clk)
      mr |=> (count == '0));

   // R2: load copies the preset
   a_r2_load_copies: assert property (@(posedge clk) disable iff (mr)
      !load_n |=> (count == $past(preset)));

   // R4: increment
   a_r4_increment: assert property (@(posedge clk) disable iff (mr)
      (load_n && $rose(up_pulse) && !$rose(dn_pulse)) |=> (count == $past(count) + ONE));

   // R4: top wraps to zero
   a_r4_wrap_top: assert property (@(posedge clk) disable iff (mr)
      (load_n && count == TOP_VAL && $rose(up_pulse) && !$rose(dn_pulse)) |=> (count == '0));

   // R5: decrement
   a_r5_decrement: assert property (@(posedge clk) disable iff (mr)
      (load_n && $rose(dn_pulse) && !$rose(up_pulse)) |=> (count == $past(count) - ONE));

   // R6: simultaneous rises cancel
   a_r6_both_hold: assert property (@(posedge clk) disable iff (mr)
      (load_n && $rose(up_pulse) && $rose(dn_pulse)) |=> $stable(count));

   // R7: no rise, no change
   a_r7_idle_hold: assert property (@(posedge clk) disable iff (mr)
      (load_n && !$rose(up_pulse) && !$rose(dn_pulse)) |=> $stable(count));

   // R8: carry low only at the top with the increment input low
   a_r8_carry_state: assert property (@(posedge clk) disable iff (mr)
      !carry_n |-> (count == TOP_VAL && !up_pulse));

   // R9: borrow low only at zero with the decrement input low
   a_r9_borrow_state: assert property (@(posedge clk) disable iff (mr)
      !borrow_n |-> (count == '0 && !dn_pulse));
endmodule

bind updn_cascade_counter updn_cascade_counter_chk #(.WIDTH(WIDTH)) u_chk (
   .clk      (clk),
   .mr       (mr),
   .load_n   (load_n),
   .preset   (preset),
   .up_pulse (up_pulse),
   .dn_pulse (dn_pulse),
   .count    (count),
   .carry_n  (carry_n),
   .borrow_n (borrow_n)
);

// File: tb/updn_cascade_counter_bench.sv
module updn_cascade_counter_bench;
   localparam int PERIOD = 10;
   localparam int W      = 4;
   localparam int MAXV   = (1 << W) - 1;

   logic clk = 1'b0;
   always #(PERIOD/2) clk = ~clk;

   logic         mr = 1'b1, load_n = 1'b1, up = 1'b0, dn = 1'b0;
   logic [W-1:0] p_lo = '0, p_hi = '0;
   logic [W-1:0] q_lo, q_hi;
   logic         c_lo, b_lo, c_hi, b_hi;

   updn_cascade_counter #(.WIDTH(W)) u_updn_cascade_counter (
      .clk(clk), .mr(mr), .load_n(load_n), .preset(p_lo),
      .up_pulse(up), .dn_pulse(dn),
      .count(q_lo), .carry_n(c_lo), .borrow_n(b_lo));

   updn_cascade_counter #(.WIDTH(W)) u_hi (
      .clk(clk), .mr(mr), .load_n(load_n), .preset(p_hi),
      .up_pulse(c_lo), .dn_pulse(b_lo),
      .count(q_hi), .carry_n(c_hi), .borrow_n(b_hi));

   int    n_cmp = 0, n_bad = 0;
   int    m_lo = 0, m_hi = 0;
   bit    pu = 0, pd = 0, pc = 1, pb = 1;
   bit    started = 0, done = 0;
   string tag_lo = "R1", tag_hi = "R1";

   function automatic bit exp_carry(int v, bit lvl);
      return !(v == MAXV && !lvl);
   endfunction
   function automatic bit exp_borrow(int v, bit lvl);
      return !(v == 0 && !lvl);
   endfunction
   function automatic int stepv(int v, bit inc, bit dec);
      if (inc && !dec) return (v + 1) & MAXV;
      if (dec && !inc) return (v + MAXV) & MAXV;
      return v;
   endfunction

   // reference model, advanced on every clock edge
   always @(posedge clk) begin
      bit c, b, ru, rd, rc, rb;
      c  = exp_carry(m_lo, up);
      b  = exp_borrow(m_lo, dn);
      ru = up && !pu;  rd = dn && !pd;
      rc = c && !pc;   rb = b && !pb;
      if (mr) begin
         m_lo = 0; m_hi = 0;
         tag_lo = load_n ? "R1" : "R3"; tag_hi = tag_lo;
      end else if (!load_n) begin
         m_lo = int'(p_lo); m_hi = int'(p_hi);
         tag_lo = "R2"; tag_hi = "R2";
      end else begin
         m_lo = stepv(m_lo, ru, rd);
         m_hi = stepv(m_hi, rc, rb);
         tag_lo = (ru && rd) ? "R6" : ru ? "R4" : rd ? "R5" : "R7";
         tag_hi = "R10";
      end
      pu = up; pd = dn; pc = c; pb = b;
      started = 1;
   end

   task automatic cmp(string tag, string what, int act, int exp);
      n_cmp++;
      if (act != exp) begin
         n_bad++;
         $display("FAIL %s %s actual=%0d expected=%0d at %0t", tag, what, act, exp, $time);
      end
   endtask

   // compare on the falling edge, away from input changes
   always @(negedge clk) begin
      if (started) begin
         bit ec;
         ec = exp_carry(m_lo, up);
         cmp(tag_lo, "low count", int'(q_lo), m_lo);
         cmp(tag_hi, "high count", int'(q_hi), m_hi);
         cmp("R8", "low carry_n", int'(c_lo), int'(ec));
         cmp("R9", "low borrow_n", int'(b_lo), int'(exp_borrow(m_lo, dn)));
         cmp("R10", "high carry_n", int'(c_hi), int'(exp_carry(m_hi, ec)));
         cmp("R10", "high borrow_n", int'(b_hi),
             int'(exp_borrow(m_hi, exp_borrow(m_lo, dn))));
      end
   end

   task automatic tick(bit u, bit d);
      up = u; dn = d;
      @(posedge clk); #1;
   endtask
   task automatic pulse_up(int n);
      for (int i = 0; i < n; i++) begin tick(1, 0); tick(0, 0); end
   endtask
   task automatic pulse_dn(int n);
      for (int i = 0; i < n; i++) begin tick(0, 1); tick(0, 0); end
   endtask
   task automatic preload(int lo, int hi);
      p_lo = W'(lo); p_hi = W'(hi); load_n = 0;
      tick(up, dn);
      load_n = 1;
   endtask

   initial begin
      // R1 clear, R3 clear together with load
      tick(0, 0);
      p_lo = 4'd9; load_n = 0; tick(1, 1);
      load_n = 1; mr = 0;
      tick(0, 0);
      // R4 counting up across the low-stage wrap (R10)
      pulse_up(20);
      // R7 levels held high are ignored
      tick(1, 0); tick(1, 0); tick(1, 1); tick(1, 1); tick(0, 0);
      // R4, R10 full wrap of the pair
      preload(14, 15);
      pulse_up(4);
      // R5, R10 down through zero
      preload(1, 0);
      pulse_dn(4);
      // R6 both rise together mid-range
      preload(5, 2);
      tick(1, 1); tick(0, 0); tick(1, 1); tick(0, 0);
      // R6 both rise at a terminal value (flags still follow per stage)
      preload(15, 3); tick(1, 1); tick(0, 0);
      preload(0, 3);  tick(1, 1); tick(0, 0);
      // R2 pulses during the load are overridden
      up = 0; p_lo = 4'd7; p_hi = 4'd12; load_n = 0;
      tick(1, 0); tick(0, 1); tick(1, 1);
      load_n = 1; tick(0, 0);
      // R8, R9 flag held low then released
      preload(15, 0); tick(0, 0); tick(0, 0); tick(1, 0); tick(0, 0);
      // weighted random levels
      for (int i = 0; i < 600; i++) begin
         int r;
         r = $urandom_range(0, 99);
         if (r < 2)      begin mr = 1; tick(up, dn); mr = 0; end
         else if (r < 5) preload($urandom_range(0, MAXV), $urandom_range(0, MAXV));
         else            tick(1'($urandom_range(0, 1)), 1'($urandom_range(0, 1)));
      end
      // R1 clear in mid count
      mr = 1; tick(1, 0); mr = 0; tick(0, 0); tick(0, 0);
      done = 1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      #(PERIOD * 150000);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired actual=running expected=finished");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end
endmodule